// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This block walks a chain of descriptors held in system memory and moves data between that memory and a byte-wide card data stream. Software points it at a table and pulses `start`. The engine fetches one descriptor, decodes it in either the compact 4-byte layout or the 8-byte layout, and then does one of three things: it moves a run of bytes, it jumps to a new table, or it steps over the entry. It then goes on to the next descriptor until the chain finishes.

A running block counter and a byte offset inside the current block persist across descriptors, so a block may be split between several table entries. A transfer can end in two ways: a descriptor carries the end attribute, or a counted block total runs out. At that point the engine checks whether the descriptor length and the block count agree, and reports a length mismatch if they do not. A descriptor whose valid bit is clear stops the engine with a fetch-stage error. After a fixed number of descriptors the engine pauses for a programmable idle window, so that it does not hold the memory port indefinitely.

Top module: `adma_engine`

## Requirements
- R1: After reset the outputs `busy`, `done`, `dma_int`, `adma_err`, `len_mismatch`, `mem_rd_en`, `mem_wr_en`, `card_take` and `card_out_valid` are 0, and `err_state` is 2'b00.
- R2: In the 8-byte layout, the first little-endian word holds attributes in bits 6:0 and length in bits 31:16. The second word holds the data address, with its bits 1:0 forced to zero. The table pointer advances by 8.
- R3: In the 4-byte layout, the data address is word bits 31:12 followed by twelve zero bits. A transfer moves 4096 bytes, and the table pointer advances by 4.
- R4: A length field of zero stands for 65536 bytes.
- R5: A descriptor with attribute bit 0 (valid) clear produces an `adma_err` pulse. It sets `err_state` to 2'b01, stops the engine, and does not pulse `done`.
- R6: The action field is attribute bits 5:4. Action 2'b11 (link) loads the table pointer from the descriptor address and moves no data.
- R7: Actions 2'b00 (no-op) and 2'b01 (set-length) move no data and only advance the table pointer.
- R8: A descriptor with attribute bit 2 (interrupt) set gives a one-cycle `dma_int` pulse after it is processed.
- R9: Processing ends with a `done` pulse when attribute bit 1 (end) is set, or when a counted block total reaches zero.
- R10: At termination, either of two conditions sets `len_mismatch` and `err_state` to 2'b10 and pulses `adma_err`: descriptor length is left over, or the end attribute arrives while the counted total is nonzero. The flag clears at the next descriptor fetch.
- R11: The byte offset within a block carries across descriptors, so a block split over two entries counts once.
- R12: After `MAX_DESC` descriptors without termination, the engine issues no memory access for `YIELD_CYC` extra cycles before it fetches again.
- R13: A start with a layout whose capability input is 0 is refused. The engine stays idle.
- R14: When `dir_rd` is 0, bytes are read from memory and presented on `card_out_data`, and no memory write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin walking the table at `tbl_addr_in` |
| fmt_b | input | 1 | 1 selects the 8-byte layout, 0 selects the 4-byte layout |
| cap_fmt_a | input | 1 | The 4-byte layout is permitted |
| cap_fmt_b | input | 1 | The 8-byte layout is permitted |
| dir_rd | input | 1 | 1: card to memory; 0: memory to card |
| cnt_en | input | 1 | Count blocks and stop at zero |
| blk_cnt_in | input | BCW | Initial block total |
| blk_size | input | BSW | Bytes per block |
| tbl_addr_in | input | 32 | Start address of the descriptor table |
| mem_rd_en | output | 1 | Memory word read request; data arrives the next cycle |
| mem_wr_en | output | 1 | Memory byte write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 32 | Little-endian word read one cycle after the request |
| card_in_data | input | 8 | Current byte from the card |
| card_take | output | 1 | Consume `card_in_data` |
| card_out_valid | output | 1 | `card_out_data` carries a byte for the card |
| card_out_data | output | 8 | Byte sent to the card |
| busy | output | 1 | Engine active |
| done | output | 1 | One-cycle pulse at normal termination |
| dma_int | output | 1 | One-cycle pulse for the interrupt attribute |
| adma_err | output | 1 | One-cycle error pulse |
| err_state | output | 2 | 00 none, 01 fetch stage, 10 transfer stage |
| len_mismatch | output | 1 | Length disagreed with the block count at termination |
| tbl_addr | output | 32 | Current table pointer |
| blk_cnt | output | BCW | Remaining block total |

## Verification
The engine is driven with single descriptors in both layouts and both directions. It is also driven with chains mixing no-op, link and transfer entries, with a zero-length descriptor, and with two short transfers that straddle a block boundary. The chains separate the pointer-advance cases from the link reload. The straddling pair separates a carried block offset from one that restarts at every descriptor. Cut-short and over-long transfers, an invalid entry, a long no-op chain and refused starts separate the two termination paths and the two error states, and the pause window from normal fetch spacing.

// File: rtl/adma_pkg.sv
package adma_pkg;
   localparam int ADDR_W = 32;
   localparam int LEN_W  = 17;

   typedef enum logic [1:0] {
      ACT_NOP    = 2'b00,
      ACT_SETLEN = 2'b01,
      ACT_XFER   = 2'b10,
      ACT_LINK   = 2'b11
   } act_e;

   typedef enum logic [1:0] {
      ERR_NONE  = 2'b00,
      ERR_FETCH = 2'b01,
      ERR_XFER  = 2'b10
   } errst_e;

   typedef enum logic [3:0] {
      S_IDLE, S_F0, S_F0W, S_F1, S_F1W, S_DEC,
      S_XR, S_XWA, S_XWB, S_POST, S_YIELD
   } st_e;

   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      logic [LEN_W-1:0]  len;
      act_e              act;
      logic              valid;
      logic              last;
      logic              irq;
   } desc_t;

   function automatic logic [LEN_W-1:0] len_of(input logic [15:0] f);
      return (f == 16'h0) ? 17'h10000 : {1'b0, f};
   endfunction
endpackage

// File: rtl/adma_desc_decode.sv
module adma_desc_decode
   import adma_pkg::*;
(
   input  logic        fmt_b,
   input  logic [31:0] w0,
   input  logic [31:0] w1,
   output desc_t       d
);
   logic unused_bits;
   assign unused_bits = ^{w0[11:6], w0[3], w1[1:0]};

   always_comb begin
      d.valid = w0[0];
      d.last  = w0[1];
      d.irq   = w0[2];
      d.act   = act_e'(w0[5:4]);
      if (fmt_b) begin
         d.addr = {w1[31:2], 2'b00};
         d.len  = len_of(w0[31:16]);
      end else begin
         d.addr = {w0[31:12], 12'h000};
         d.len  = (w0[5:4] == ACT_SETLEN) ? len_of(w0[27:12]) : 17'h01000;
      end
   end
endmodule

// File: rtl/adma_blk_track.sv
module adma_blk_track #(
   parameter int BSW = 12,
   parameter int BCW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [BCW-1:0] cnt_in,
   input  logic [BSW-1:0] bsize,
   input  logic           cnt_en,
   input  logic           step,
   output logic [BCW-1:0] cnt,
   output logic           last_blk
);
   logic [BSW-1:0] off;
   logic           wrap;

   assign wrap     = (off == (bsize - BSW'(1)));
   assign last_blk = wrap && cnt_en && (cnt == BCW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off <= '0;
         cnt <= '0;
      end else if (load) begin
         off <= '0;
         cnt <= cnt_in;
      end else if (step) begin
         off <= wrap ? '0 : off + BSW'(1);
         if (wrap && cnt_en) cnt <= cnt - BCW'(1);
      end
   end
endmodule

// File: rtl/adma_engine.sv
module adma_engine
   import adma_pkg::*;
#(
   parameter int BSW       = 12,
   parameter int BCW       = 16,
   parameter int MAX_DESC  = 4,
   parameter int YIELD_CYC = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           fmt_b,
   input  logic           cap_fmt_a,
   input  logic           cap_fmt_b,
   input  logic           dir_rd,
   input  logic           cnt_en,
   input  logic [BCW-1:0] blk_cnt_in,
   input  logic [BSW-1:0] blk_size,
   input  logic [31:0]    tbl_addr_in,
   output logic           mem_rd_en,
   output logic           mem_wr_en,
   output logic [31:0]    mem_addr,
   output logic [7:0]     mem_wdata,
   input  logic [31:0]    mem_rdata,
   input  logic [7:0]     card_in_data,
   output logic           card_take,
   output logic           card_out_valid,
   output logic [7:0]     card_out_data,
   output logic           busy,
   output logic           done,
   output logic           dma_int,
   output logic           adma_err,
   output logic [1:0]     err_state,
   output logic           len_mismatch,
   output logic [31:0]    tbl_addr,
   output logic [BCW-1:0] blk_cnt
);
   localparam int DCW = $clog2(MAX_DESC + 1);
   localparam int YCW = $clog2((YIELD_CYC > 1) ? YIELD_CYC : 2);

   generate
      if (BSW < 2 || BSW > 16) begin : g_bad_bsw
         $error("BSW must lie in 2..16");
      end
      if (BCW < 1) begin : g_bad_bcw
         $error("BCW must be positive");
      end
      if (MAX_DESC < 1 || YIELD_CYC < 1) begin : g_bad_yield
         $error("MAX_DESC and YIELD_CYC must be at least 1");
      end
   endgenerate

   st_e              st;
   logic             fmt_r, dir_r, cen_r;
   logic [BSW-1:0]   bs_r;
   logic [31:0]      w0, w1, daddr;
   logic [LEN_W-1:0] rem;
   logic             last_f, irq_f;
   logic [DCW-1:0]   ndesc;
   desc_t            dsc;
   logic             start_ok, step, last_blk, terminate, mismatch, yield_over;
   logic [31:0]      inc;

   adma_desc_decode u_dec (.fmt_b(fmt_r), .w0(w0), .w1(w1), .d(dsc));

   assign start_ok = (st == S_IDLE) && start && (fmt_b ? cap_fmt_b : cap_fmt_a);

   adma_blk_track #(.BSW(BSW), .BCW(BCW)) u_blk (
      .clk(clk), .rst_n(rst_n), .load(start_ok), .cnt_in(blk_cnt_in),
      .bsize(bs_r), .cnt_en(cen_r), .step(step), .cnt(blk_cnt),
      .last_blk(last_blk)
   );

   generate
      if (YIELD_CYC > 1) begin : g_ywait
         logic [YCW-1:0] ycnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              ycnt <= '0;
            else if (st != S_YIELD)  ycnt <= '0;
            else                     ycnt <= ycnt + YCW'(1);
         end
         assign yield_over = (ycnt == YCW'(YIELD_CYC - 1));
      end else begin : g_ynone
         assign yield_over = 1'b1;
      end
   endgenerate

   assign busy           = (st != S_IDLE);
   assign mem_rd_en      = (st == S_F0) || (st == S_F1) || (st == S_XWA);
   assign mem_addr       = (st == S_F0) ? tbl_addr :
                           (st == S_F1) ? tbl_addr + 32'd4 : daddr;
   assign mem_wr_en      = (st == S_XR);
   assign mem_wdata      = card_in_data;
   assign card_take      = (st == S_XR);
   assign card_out_valid = (st == S_XWB);
   assign card_out_data  = mem_rdata[8*daddr[1:0] +: 8];
   assign step           = card_take || card_out_valid;
   assign inc            = fmt_r ? 32'd8 : 32'd4;
   assign terminate      = last_f || (cen_r && blk_cnt == '0);
   assign mismatch       = (rem != '0) || (last_f && cen_r && blk_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE;
         {fmt_r, dir_r, cen_r, last_f, irq_f} <= '0;
         bs_r <= '0; w0 <= '0; w1 <= '0; daddr <= '0; rem <= '0;
         ndesc <= '0; tbl_addr <= '0;
         done <= 1'b0; dma_int <= 1'b0; adma_err <= 1'b0;
         err_state <= ERR_NONE; len_mismatch <= 1'b0;
      end else begin
         done     <= 1'b0;
         dma_int  <= 1'b0;
         adma_err <= 1'b0;
         case (st)
            S_IDLE: if (start_ok) begin
               tbl_addr <= tbl_addr_in;
               fmt_r <= fmt_b; dir_r <= dir_rd; cen_r <= cnt_en; bs_r <= blk_size;
               ndesc <= '0; err_state <= ERR_NONE; len_mismatch <= 1'b0;
               st <= S_F0;
            end
            S_F0: begin
               len_mismatch <= 1'b0;
               st <= S_F0W;
            end
            S_F0W: begin
               w0 <= mem_rdata;
               st <= fmt_r ? S_F1 : S_DEC;
            end
            S_F1:  st <= S_F1W;
            S_F1W: begin
               w1 <= mem_rdata;
               st <= S_DEC;
            end
            S_DEC: begin
               last_f <= dsc.last;
               irq_f  <= dsc.irq;
               rem    <= '0;
               if (!dsc.valid) begin
                  adma_err  <= 1'b1;
                  err_state <= ERR_FETCH;
                  st        <= S_IDLE;
               end else begin
                  case (dsc.act)
                     ACT_XFER: begin
                        daddr    <= dsc.addr;
                        rem      <= dsc.len;
                        tbl_addr <= tbl_addr + inc;
                        st       <= dir_r ? S_XR : S_XWA;
                     end
                     ACT_LINK: begin
                        tbl_addr <= dsc.addr;
                        st       <= S_POST;
                     end
                     default: begin
                        tbl_addr <= tbl_addr + inc;
                        st       <= S_POST;
                     end
                  endcase
               end
            end
            S_XWA: st <= S_XWB;
            S_XR, S_XWB: begin
               daddr <= daddr + 32'd1;
               rem   <= rem - LEN_W'(1);
               if (last_blk || rem == LEN_W'(1)) st <= S_POST;
               else                              st <= dir_r ? S_XR : S_XWA;
            end
            S_POST: begin
               dma_int <= irq_f;
               if (terminate) begin
                  done <= 1'b1;
                  if (mismatch) begin
                     len_mismatch <= 1'b1;
                     err_state    <= ERR_XFER;
                     adma_err     <= 1'b1;
                  end
                  st <= S_IDLE;
               end else if (ndesc == DCW'(MAX_DESC - 1)) begin
                  ndesc <= '0;
                  st    <= S_YIELD;
               end else begin
                  ndesc <= ndesc + DCW'(1);
                  st    <= S_F0;
               end
            end
            S_YIELD: if (yield_over) st <= S_F0;
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adma_engine_chk.sv
module adma_engine_chk #(
   parameter int BCW = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic           busy,
   input logic           done,
   input logic           dma_int,
   input logic           adma_err,
   input logic [1:0]     err_state,
   input logic           len_mismatch,
   input logic [BCW-1:0] blk_cnt,
   input logic           mem_rd_en,
   input logic           mem_wr_en,
   input logic           card_take,
   input logic           card_out_valid
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_rd_en && !mem_wr_en && !card_take && !card_out_valid); // R13
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R9
   AST_MISMATCH_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      len_mismatch |-> err_state == 2'b10); // R10
   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (adma_err && done) |-> len_mismatch); // R10
   AST_FETCH_ERR_NODONE: assert property (@(posedge clk) disable iff (!rst_n)
      (adma_err && err_state == 2'b01) |-> !done); // R5
   AST_BLK_NONINC: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> blk_cnt <= $past(blk_cnt)); // R11
   AST_INT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      dma_int |=> !dma_int); // R8
   AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_en && mem_wr_en)); // R14
endmodule

bind adma_engine adma_engine_chk #(.BCW(BCW)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .dma_int(dma_int),
   .adma_err(adma_err), .err_state(err_state), .len_mismatch(len_mismatch),
   .blk_cnt(blk_cnt), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
   .card_take(card_take), .card_out_valid(card_out_valid)
);

// File: tb/adma_engine_bench.sv
module adma_engine_bench;
   localparam int YC = 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n, start, fmt_b, cap_fmt_a, cap_fmt_b, dir_rd, cnt_en;
   logic [15:0] blk_cnt_in;
   logic [11:0] blk_size;
   logic [31:0] tbl_addr_in;
   logic        mem_rd_en, mem_wr_en, card_take, card_out_valid;
   logic [31:0] mem_addr, mem_rdata, tbl_addr;
   logic [7:0]  mem_wdata, card_out_data;
   logic [7:0]  card_seq = 8'h00;
   logic        busy, done, dma_int, adma_err, len_mismatch;
   logic [1:0]  err_state;
   logic [15:0] blk_cnt;

   adma_engine #(.BSW(12), .BCW(16), .MAX_DESC(4), .YIELD_CYC(YC)) u_adma_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .fmt_b(fmt_b),
      .cap_fmt_a(cap_fmt_a), .cap_fmt_b(cap_fmt_b), .dir_rd(dir_rd),
      .cnt_en(cnt_en), .blk_cnt_in(blk_cnt_in), .blk_size(blk_size),
      .tbl_addr_in(tbl_addr_in), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .card_in_data(card_seq), .card_take(card_take),
      .card_out_valid(card_out_valid), .card_out_data(card_out_data),
      .busy(busy), .done(done), .dma_int(dma_int), .adma_err(adma_err),
      .err_state(err_state), .len_mismatch(len_mismatch),
      .tbl_addr(tbl_addr), .blk_cnt(blk_cnt)
   );

   int checks = 0;
   int errors = 0;

   logic [7:0]  mem [0:8191];
   logic        tbw = 1'b0;
   logic [12:0] tba = '0;
   logic [7:0]  tbd = '0;
   logic        mclr = 1'b0;
   int          cyc = 0, takes = 0, wrs = 0, rd_n = 0, cap_n = 0;
   int          rd_cyc [0:31];
   logic [7:0]  cap [0:15];
   logic        done_seen = 1'b0, err_seen = 1'b0, int_seen = 1'b0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_rd_en)
         mem_rdata <= {mem[{mem_addr[12:2], 2'd3}], mem[{mem_addr[12:2], 2'd2}],
                       mem[{mem_addr[12:2], 2'd1}], mem[{mem_addr[12:2], 2'd0}]};
      if (mem_wr_en) mem[mem_addr[12:0]] <= mem_wdata;
      if (tbw) mem[tba] <= tbd;
      if (card_take) card_seq <= card_seq + 8'd1;
      if (mclr) begin
         takes <= 0; wrs <= 0; rd_n <= 0; cap_n <= 0;
         done_seen <= 1'b0; err_seen <= 1'b0; int_seen <= 1'b0;
      end else begin
         if (card_take) takes <= takes + 1;
         if (mem_wr_en) wrs <= wrs + 1;
         if (mem_rd_en && rd_n < 32) begin
            rd_cyc[rd_n] <= cyc;
            rd_n <= rd_n + 1;
         end
         if (card_out_valid && cap_n < 16) begin
            cap[cap_n] <= card_out_data;
            cap_n <= cap_n + 1;
         end
         if (done) done_seen <= 1'b1;
         if (adma_err) err_seen <= 1'b1;
         if (dma_int) int_seen <= 1'b1;
      end
   end

   task automatic chk(input string r, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
      end
   endtask

   task automatic poke(input logic [12:0] a, input logic [7:0] d);
      @(negedge clk); tbw = 1'b1; tba = a; tbd = d;
      @(negedge clk); tbw = 1'b0;
   endtask

   task automatic poke32(input logic [12:0] a, input logic [31:0] w);
      for (int i = 0; i < 4; i++) poke(a + 13'(i), w[8*i +: 8]);
   endtask

   task automatic desc_b(input logic [12:0] a, input logic [6:0] attr,
                         input logic [15:0] len, input logic [31:0] addr);
      poke32(a, {len, 9'd0, attr});
      poke32(a + 13'd4, addr);
   endtask

   task automatic clr_mon();
      @(negedge clk); mclr = 1'b1;
      @(negedge clk); mclr = 1'b0;
   endtask

   task automatic go(input logic fb, input logic rd, input logic ce,
                     input logic [15:0] cnt, input logic [11:0] bs,
                     input logic [31:0] tbl);
      @(negedge clk);
      fmt_b = fb; dir_rd = rd; cnt_en = ce; blk_cnt_in = cnt;
      blk_size = bs; tbl_addr_in = tbl; start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic wait_fin();
      for (int i = 0; i < 100000; i++) begin
         @(negedge clk);
         if (done_seen || err_seen) break;
      end
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1", "busy", busy, 0);
      chk("R1", "done", done, 0);
      chk("R1", "adma_err", adma_err, 0);
      chk("R1", "err_state", err_state, 0);
      chk("R1", "len_mismatch", len_mismatch, 0);
      chk("R1", "mem_rd_en", mem_rd_en, 0);
      chk("R1", "card_take|card_out_valid", card_take | card_out_valid, 0);
   endtask

   task automatic t_fmt_b_read();
      logic [7:0] s0;
      poke(13'h206, 8'hEE);
      desc_b(13'h100, 7'h27, 16'd6, 32'h203);
      clr_mon();
      s0 = card_seq;
      go(1'b1, 1'b1, 1'b0, 16'd0, 12'd4, 32'h100);
      wait_fin();
      chk("R2", "bytes taken", takes, 6);
      chk("R2", "first byte at aligned addr", mem[13'h200], s0);
      chk("R2", "last byte", mem[13'h205], s0 + 8'd5);
      chk("R2", "byte past run untouched", mem[13'h206], 8'hEE);
      chk("R2", "table advance by 8", tbl_addr, 32'h108);
      chk("R9", "done on end attribute", done_seen, 1);
      chk("R8", "interrupt pulse", int_seen, 1);
      chk("R10", "no mismatch", len_mismatch, 0);
   endtask

   task automatic t_fmt_a();
      logic [7:0] s0;
      poke32(13'h140, {20'h00001, 5'd0, 7'h21});
      clr_mon();
      s0 = card_seq;
      go(1'b0, 1'b1, 1'b1, 16'd4, 12'd1024, 32'h140);
      wait_fin();
      chk("R3", "4096 bytes taken", takes, 4096);
      chk("R3", "first byte at 4K address", mem[13'h1000], s0);
      chk("R3", "last byte", mem[13'h1FFF], s0 - 8'd1);
      chk("R3", "table advance by 4", tbl_addr, 32'h144);
      chk("R9", "done on count zero", done_seen, 1);
      chk("R9", "block count exhausted", blk_cnt, 0);
      chk("R10", "no mismatch", len_mismatch, 0);
   endtask

   task automatic t_zero_len();
      desc_b(13'h180, 7'h21, 16'd0, 32'h0);
      clr_mon();
      go(1'b1, 1'b1, 1'b1, 16'd4096, 12'd16, 32'h180);
      wait_fin();
      chk("R4", "zero length moves 65536", takes, 65536);
      chk("R4", "no mismatch", len_mismatch, 0);
      chk("R4", "done", done_seen, 1);
   endtask

   task automatic t_invalid();
      desc_b(13'h300, 7'h00, 16'd4, 32'h400);
      clr_mon();
      go(1'b1, 1'b1, 1'b0, 16'd0, 12'd4, 32'h300);
      wait_fin();
      chk("R5", "error pulse", err_seen, 1);
      chk("R5", "fetch state", err_state, 2'b01);
      chk("R5", "no done", done_seen, 0);
      chk("R5", "stopped", busy, 0);
      chk("R5", "no data", takes, 0);
   endtask

   task automatic t_link_nop();
      logic [7:0] s0;
      desc_b(13'h400, 7'h01, 16'd5, 32'h998);
      desc_b(13'h408, 7'h31, 16'd0, 32'h500);
      desc_b(13'h500, 7'h23, 16'd2, 32'h600);
      clr_mon();
      s0 = card_seq;
      go(1'b1, 1'b1, 1'b0, 16'd0, 12'd4, 32'h400);
      wait_fin();
      chk("R7", "no-op and link move nothing", takes, 2);
      chk("R7", "memory writes", wrs, 2);
      chk("R6", "link then advance", tbl_addr, 32'h508);
      chk("R6", "data after link", mem[13'h601], s0 + 8'd1);
      chk("R8", "no interrupt without attribute", int_seen, 0);
   endtask

   task automatic t_write();
      poke(13'h710, 8'hAA); poke(13'h711, 8'hBB); poke(13'h712, 8'hCC);
      desc_b(13'h700, 7'h23, 16'd3, 32'h711);
      clr_mon();
      go(1'b1, 1'b0, 1'b0, 16'd0, 12'd4, 32'h700);
      wait_fin();
      chk("R14", "card byte count", cap_n, 3);
      chk("R14", "byte 0", cap[0], 8'hAA);
      chk("R14", "byte 2", cap[2], 8'hCC);
      chk("R14", "no memory writes", wrs, 0);
      chk("R14", "no card takes", takes, 0);
   endtask

   task automatic t_partial();
      desc_b(13'h800, 7'h21, 16'd3, 32'h900);
      desc_b(13'h808, 7'h21, 16'd5, 32'h910);
      desc_b(13'h810, 7'h00, 16'd0, 32'h0);
      clr_mon();
      go(1'b1, 1'b1, 1'b1, 16'd2, 12'd4, 32'h800);
      wait_fin();
      chk("R11", "done after split block", done_seen, 1);
      chk("R11", "no fetch error", err_seen, 0);
      chk("R11", "bytes", takes, 8);
      chk("R11", "count zero", blk_cnt, 0);
      chk("R11", "stopped before trap entry", tbl_addr, 32'h810);
   endtask

   task automatic t_mismatch();
      desc_b(13'hB00, 7'h21, 16'd6, 32'h980);
      clr_mon();
      go(1'b1, 1'b1, 1'b1, 16'd1, 12'd4, 32'hB00);
      wait_fin();
      chk("R10", "leftover length flagged", len_mismatch, 1);
      chk("R10", "transfer state", err_state, 2'b10);
      chk("R10", "error pulse", err_seen, 1);
      chk("R9", "cut at count zero", takes, 4);
      desc_b(13'hB10, 7'h23, 16'd4, 32'h980);
      clr_mon();
      go(1'b1, 1'b1, 1'b1, 16'd3, 12'd4, 32'hB10);
      wait_fin();
      chk("R10", "end with blocks left flagged", len_mismatch, 1);
      chk("R10", "blocks left", blk_cnt, 2);
      desc_b(13'hB20, 7'h23, 16'd2, 32'h980);
      clr_mon();
      go(1'b1, 1'b1, 1'b0, 16'd0, 12'd4, 32'hB20);
      wait_fin();
      chk("R10", "flag cleared on next fetch", len_mismatch, 0);
      chk("R10", "no error", err_seen, 0);
   endtask

   task automatic t_yield();
      for (int i = 0; i < 4; i++) desc_b(13'hA00 + 13'(8*i), 7'h01, 16'd1, 32'h0);
      desc_b(13'hA20, 7'h03, 16'd1, 32'h0);
      clr_mon();
      go(1'b1, 1'b1, 1'b0, 16'd0, 12'd4, 32'hA00);
      wait_fin();
      chk("R12", "fetch reads", rd_n, 10);
      chk("R12", "normal fetch spacing", rd_cyc[2] - rd_cyc[0], 6);
      chk("R12", "spacing across pause", rd_cyc[8] - rd_cyc[6], 6 + YC);
      chk("R7", "no-op chain moves nothing", takes, 0);
   endtask

   task automatic t_cap();
      cap_fmt_a = 1'b0;
      clr_mon();
      go(1'b0, 1'b1, 1'b0, 16'd0, 12'd4, 32'h140);
      repeat (6) @(negedge clk);
      chk("R13", "4-byte layout refused", busy, 0);
      chk("R13", "no fetch", rd_n, 0);
      cap_fmt_a = 1'b1; cap_fmt_b = 1'b0;
      clr_mon();
      go(1'b1, 1'b1, 1'b0, 16'd0, 12'd4, 32'h100);
      repeat (6) @(negedge clk);
      chk("R13", "8-byte layout refused", busy, 0);
      chk("R13", "no fetch", rd_n, 0);
      cap_fmt_b = 1'b1;
   endtask

   initial begin
      rst_n = 1'b0; start = 1'b0; fmt_b = 1'b1; cap_fmt_a = 1'b1; cap_fmt_b = 1'b1;
      dir_rd = 1'b1; cnt_en = 1'b0; blk_cnt_in = '0; blk_size = 12'd4;
      tbl_addr_in = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_fmt_b_read();
      t_fmt_a();
      t_zero_len();
      t_invalid();
      t_link_nop();
      t_write();
      t_partial();
      t_mismatch();
      t_yield();
      t_cap();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule